// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer with Dead Time and Protection Gating

This block turns one pulse-width command into two gate enables for a half-bridge: a high-side enable that follows the command and a low-side enable that follows its inverse. Between the two, the block always leaves a fixed gap in which both switches are off. This lets the device that is turning off finish switching before its partner starts to conduct. All timing is counted in clock cycles. The cycle counts come from nanosecond parameters and the clock period.

The outputs are also gated by four protection flags:
- An active-low shutdown turns both sides off.
- A logic-supply good flag turns both sides off while it is low, including at power-up.
- A floating-supply good flag turns off only the high side.
- A switch-node undershoot flag blanks the high side for a fixed hold time, but only once it has stayed asserted past a qualification time.

Every flag and the command pass through two-flop synchronizers. An output that is re-enabled after any kind of gating waits a full dead time before it turns on.

Top module: `hb_gate_ctrl`

## Requirements
- R1: In steady state with all protection inactive, `hs_gate` equals `cmd_in` and `ls_gate` equals its inverse.
- R2: Dead time is DEAD_CYC = ceil(DEAD_NS / CLK_NS) cycles, which is 27 at the defaults of 530 ns and 20 ns. A conducting output that must turn off falls on the 3rd rising edge after the input change. That is two synchronizer stages plus one output register. The opposite output rises exactly DEAD_CYC edges after that fall. An output whose enable becomes true while the opposite output is already off rises on edge 2 + DEAD_CYC after the enabling input change.
- R3: `hs_gate` and `ls_gate` are never both high in any cycle.
- R4: If the command returns before the dead time completes, the pending turn-on is cancelled and counting restarts for the other side. A command pulse shorter than DEAD_CYC cycles never reaches either output.
- R5: While `shdn_n` is low, both outputs are off. After it returns high, an output turns on only under the R2 rule for an already-off opposite side, even if the command already requests that output.
- R6: While `lsup_ok` is low, both outputs are off. After reset nothing is driven until `lsup_ok` is seen high, and re-enabling follows the same rule as in R5.
- R7: While `fsup_ok` is low, only `hs_gate` is forced off. `ls_gate` keeps following the command, with the usual dead time.
- R8: QUAL_CYC = ceil(QUAL_NS / CLK_NS) cycles, which is 3 at the defaults. HOLD_CYC = ceil(HOLD_NS / CLK_NS) cycles, which is 225 at the defaults.
  - When `sw_neg_flag`, after synchronization, stays high for QUAL_CYC consecutive cycles, the high side is blanked for HOLD_CYC cycles. If `hs_gate` was on, it falls 6 edges after the flag rises.
  - When the blank ends, `hs_gate` turns on again 5 + HOLD_CYC + DEAD_CYC edges after the flag rise, if the command still requests it.
  - Shorter flag pulses have no effect.
  - `ls_gate` is not affected by the blank.
- R9: While `rst_n` is low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_in | input | 1 | PWM command: 1 requests the high side, 0 requests the low side |
| shdn_n | input | 1 | Active-low shutdown |
| lsup_ok | input | 1 | Logic and low-side supply good flag |
| fsup_ok | input | 1 | Floating high-side supply good flag |
| sw_neg_flag | input | 1 | Switch-node negative transient detected |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
The assertions assume that all inputs are asynchronous and are only ever looked at after the synchronizers. The stimulus therefore changes inputs on the falling clock edge and holds each value for many cycles. The dead-time checks also assume the synchronized command gives each side a clean request, with no two-side request in the same cycle; this holds by construction because the two requests are complements. The stimulus changes one protection flag at a time and waits for each transition to settle before the next one. As a result, every expected output edge has a single predictable cycle.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

  // Round a nanosecond interval up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cycles(input int unsigned dur_ns,
                                               input int unsigned period_ns);
    int unsigned c;
    c = (dur_ns + period_ns - 1) / period_ns;
    return (c == 0) ? 1 : c;
  endfunction

  // Bits needed to hold the values 0 .. n.
  function automatic int unsigned span_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/hb_sync2.sv
module hb_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/hb_dead_chan.sv
module hb_dead_chan
  import hb_gate_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 27
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_i,
  input  logic peer_on_i,
  output logic on_o
);
  localparam int unsigned CW = span_bits(DEAD_CYC);
  localparam logic [CW-1:0] LAST = CW'(DEAD_CYC - 1);
  localparam logic [CW-1:0] FULL = CW'(DEAD_CYC);

  logic [CW-1:0] wait_q;
  logic          on_q;
  logic [CW-1:0] peer_off_q;

  // Internal events, brought out for the assertions.
  wire arm_w  = want_i & ~on_q & ~peer_on_i;
  wire fire_w = arm_w & (wait_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
      on_q   <= 1'b0;
    end else if (!want_i) begin
      wait_q <= '0;
      on_q   <= 1'b0;
    end else if (on_q) begin
      wait_q <= '0;
    end else if (peer_on_i) begin
      wait_q <= '0;
    end else if (fire_w) begin
      wait_q <= '0;
      on_q   <= 1'b1;
    end else begin
      wait_q <= wait_q + 1'b1;
    end
  end

  // Saturating count of cycles the peer output has been off.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 peer_off_q <= FULL;
    else if (peer_on_i)         peer_off_q <= '0;
    else if (peer_off_q != FULL) peer_off_q <= peer_off_q + 1'b1;
  end

  assign on_o = on_q;

  // R2
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_q) |-> (peer_off_q == FULL));

  // R2
  prompt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !want_i |=> !on_q);

  // R4
  no_early_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!on_q && !fire_w) |=> !on_q);
endmodule

// File: rtl/hb_neg_blank.sv
module hb_neg_blank
  import hb_gate_pkg::*;
#(
  parameter int unsigned QUAL_CYC = 3,
  parameter int unsigned HOLD_CYC = 225
) (
  input  logic clk,
  input  logic rst_n,
  input  logic neg_i,
  output logic blank_o
);
  localparam int unsigned QW = span_bits(QUAL_CYC);
  localparam int unsigned HW = span_bits(HOLD_CYC);
  localparam logic [QW-1:0] QLAST = QW'(QUAL_CYC - 1);
  localparam logic [HW-1:0] HLOAD = HW'(HOLD_CYC);

  logic [QW-1:0] qual_q;
  logic [HW-1:0] hold_q;

  wire trig_w = neg_i & (qual_q == QLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       qual_q <= '0;
    else if (!neg_i)  qual_q <= '0;
    else if (trig_w)  qual_q <= '0;
    else              qual_q <= qual_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             hold_q <= '0;
    else if (trig_w)        hold_q <= HLOAD;
    else if (hold_q != '0)  hold_q <= hold_q - 1'b1;
  end

  assign blank_o = (hold_q != '0);

  // R8
  trig_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_w |=> blank_o);

  // R8
  blank_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blank_o) |-> $past(neg_i));
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_gate_pkg::*;
#(
  parameter int unsigned CLK_NS  = 20,
  parameter int unsigned DEAD_NS = 530,
  parameter int unsigned QUAL_NS = 50,
  parameter int unsigned HOLD_NS = 4500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_in,
  input  logic shdn_n,
  input  logic lsup_ok,
  input  logic fsup_ok,
  input  logic sw_neg_flag,
  output logic hs_gate,
  output logic ls_gate
);
  localparam int unsigned DEAD_CYC = ns_to_cycles(DEAD_NS, CLK_NS);
  localparam int unsigned QUAL_CYC = ns_to_cycles(QUAL_NS, CLK_NS);
  localparam int unsigned HOLD_CYC = ns_to_cycles(HOLD_NS, CLK_NS);

  logic cmd_s, shdn_s, lsup_s, fsup_s, neg_s;
  logic blank_w;
  logic [1:0] want_w;   // [0] high side, [1] low side
  logic [1:0] on_w;

  hb_sync2 #(.W(5)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({cmd_in, shdn_n, lsup_ok, fsup_ok, sw_neg_flag}),
    .q_o   ({cmd_s, shdn_s, lsup_s, fsup_s, neg_s})
  );

  hb_neg_blank #(.QUAL_CYC(QUAL_CYC), .HOLD_CYC(HOLD_CYC)) u_blank (
    .clk     (clk),
    .rst_n   (rst_n),
    .neg_i   (neg_s),
    .blank_o (blank_w)
  );

  // Asymmetric gating: logic supply and shutdown kill both sides,
  // floating supply and transient blank kill the high side only.
  assign want_w[0] =  cmd_s & shdn_s & lsup_s & fsup_s & ~blank_w;
  assign want_w[1] = ~cmd_s & shdn_s & lsup_s;

  for (genvar g = 0; g < 2; g++) begin : g_side
    hb_dead_chan #(.DEAD_CYC(DEAD_CYC)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .want_i    (want_w[g]),
      .peer_on_i (on_w[1-g]),
      .on_o      (on_w[g])
    );
  end

  assign hs_gate = on_w[0];
  assign ls_gate = on_w[1];

  // R3
  overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));

  // R5
  shdn_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_s |=> (!hs_gate && !ls_gate));

  // R6
  lsup_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lsup_s |=> (!hs_gate && !ls_gate));

  // R7
  fsup_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fsup_s |=> !hs_gate);

  // R8
  blank_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank_w |=> !hs_gate);

  // R9
  always_comb begin
    if (!rst_n) begin
      reset_low_chk: assert (!hs_gate && !ls_gate);
    end
  end
endmodule

// File: tb/hb_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module hb_gate_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_in = 1'b0, shdn_n = 1'b1, lsup_ok = 1'b1, fsup_ok = 1'b1, sw_neg_flag = 1'b0;
  logic hs_gate, ls_gate;

  always #10 clk = ~clk;   // 50 MHz

  hb_gate_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .shdn_n(shdn_n),
    .lsup_ok(lsup_ok), .fsup_ok(fsup_ok), .sw_neg_flag(sw_neg_flag),
    .hs_gate(hs_gate), .ls_gate(ls_gate)
  );

  typedef struct { int cyc; logic h; logic l; string req; } ev_t;
  ev_t exp_q[$];

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int d_cyc, h_cyc;
  bit done = 0;
  logic [1:0] prev_q = 2'b00;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: every output change must match the next expected item.
  always @(negedge clk) begin
    if (rst_n && ({hs_gate, ls_gate} != prev_q)) begin
      n_chk++;
      if (hs_gate && ls_gate) begin
        n_bad++;
        $display("FAIL R3: {ho,lo} actual 11 expected not both high at cycle %0d", cyc);
      end
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R1: unexpected change, actual %b%b expected no change at cycle %0d",
                 hs_gate, ls_gate, cyc);
      end else begin
        ev_t e;
        e = exp_q.pop_front();
        if (e.cyc != cyc || e.h !== hs_gate || e.l !== ls_gate) begin
          n_bad++;
          $display("FAIL %s: actual %b%b at cycle %0d, expected %b%b at cycle %0d",
                   e.req, hs_gate, ls_gate, cyc, e.h, e.l, e.cyc);
        end
      end
      prev_q = {hs_gate, ls_gate};
    end
  end

  task automatic push(input int c, input logic h, input logic l, input string r);
    ev_t e;
    e.cyc = c; e.h = h; e.l = l; e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string r, input logic [1:0] exp);
    n_chk++;
    if ({hs_gate, ls_gate} !== exp) begin
      n_bad++;
      $display("FAIL %s: {ho,lo} actual %b%b expected %b at cycle %0d",
               r, hs_gate, ls_gate, exp, cyc);
    end
  endtask

  // Toggle the command with the opposite side currently conducting.
  task automatic step_cmd(input logic v, input string r);
    int c;
    @(negedge clk); c = cyc; cmd_in = v;
    push(c + 3, 1'b0, 1'b0, r);
    push(c + 3 + d_cyc, v, ~v, r);
    wait_cyc(d_cyc + 10);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int c;
    d_cyc = int'($ceil(530.0 / 20.0));    // R2
    h_cyc = int'($ceil(4500.0 / 20.0));   // R8

    wait_cyc(3);
    check("R9", 2'b00);

    // R6 / R9: release reset, low side powers up after a full dead time
    @(negedge clk); c = cyc; rst_n = 1'b1;
    push(c + 2 + d_cyc, 1'b0, 1'b1, "R6");
    wait_cyc(d_cyc + 10);
    check("R1", 2'b01);

    // R1 R2: both transitions
    step_cmd(1'b1, "R2");
    check("R1", 2'b10);
    step_cmd(1'b0, "R2");

    // R4: pulse shorter than the dead time
    @(negedge clk); c = cyc; cmd_in = 1'b1;
    push(c + 3, 1'b0, 1'b0, "R4");
    push(c + 12 + d_cyc, 1'b0, 1'b1, "R4");
    wait_cyc(10); cmd_in = 1'b0;
    wait_cyc(d_cyc + 15);
    check("R4", 2'b01);
    step_cmd(1'b1, "R1");

    // R5: shutdown, command change while shut down, release
    @(negedge clk); c = cyc; shdn_n = 1'b0;
    push(c + 3, 1'b0, 1'b0, "R5");
    wait_cyc(10); cmd_in = 1'b0;
    wait_cyc(d_cyc + 10);
    check("R5", 2'b00);
    @(negedge clk); c = cyc; shdn_n = 1'b1;
    push(c + 2 + d_cyc, 1'b0, 1'b1, "R5");
    wait_cyc(d_cyc + 10);
    step_cmd(1'b1, "R1");

    // R7: floating supply low kills only the high side
    @(negedge clk); c = cyc; fsup_ok = 1'b0;
    push(c + 3, 1'b0, 1'b0, "R7");
    wait_cyc(10);
    @(negedge clk); c = cyc; cmd_in = 1'b0;
    push(c + 2 + d_cyc, 1'b0, 1'b1, "R7");
    wait_cyc(d_cyc + 10);
    check("R7", 2'b01);
    @(negedge clk); c = cyc; cmd_in = 1'b1;
    push(c + 3, 1'b0, 1'b0, "R7");
    wait_cyc(d_cyc + 10);
    check("R7", 2'b00);
    @(negedge clk); c = cyc; fsup_ok = 1'b1;
    push(c + 2 + d_cyc, 1'b1, 1'b0, "R7");
    wait_cyc(d_cyc + 10);

    // R6: logic supply low kills both sides
    step_cmd(1'b0, "R1");
    @(negedge clk); c = cyc; lsup_ok = 1'b0;
    push(c + 3, 1'b0, 1'b0, "R6");
    wait_cyc(10); cmd_in = 1'b1;
    wait_cyc(d_cyc + 10);
    check("R6", 2'b00);
    @(negedge clk); c = cyc; lsup_ok = 1'b1;
    push(c + 2 + d_cyc, 1'b1, 1'b0, "R6");
    wait_cyc(d_cyc + 10);

    // R8: two-cycle transient is ignored
    @(negedge clk); sw_neg_flag = 1'b1;
    wait_cyc(2); sw_neg_flag = 1'b0;
    wait_cyc(20);
    check("R8", 2'b10);

    // R8: qualified transient, full hold, then high side returns
    @(negedge clk); c = cyc; sw_neg_flag = 1'b1;
    push(c + 6, 1'b0, 1'b0, "R8");
    push(c + 5 + h_cyc + d_cyc, 1'b1, 1'b0, "R8");
    wait_cyc(4); sw_neg_flag = 1'b0;
    wait_cyc(h_cyc - 10);
    check("R8", 2'b00);
    wait_cyc(d_cyc + 30);
    check("R8", 2'b10);

    // R8: low side keeps working during the blank
    @(negedge clk); c = cyc; sw_neg_flag = 1'b1;
    push(c + 6, 1'b0, 1'b0, "R8");
    wait_cyc(4); sw_neg_flag = 1'b0;
    wait_cyc(15);
    @(negedge clk); c = cyc; cmd_in = 1'b0;
    push(c + 2 + d_cyc, 1'b0, 1'b1, "R8");
    wait_cyc(h_cyc + 10);
    check("R8", 2'b01);
    step_cmd(1'b1, "R2");

    wait_cyc(10);
    while (exp_q.size() != 0) begin
      ev_t e;
      e = exp_q.pop_front();
      n_chk++; n_bad++;
      $display("FAIL %s: actual no change expected %b%b at cycle %0d",
               e.req, e.h, e.l, e.cyc);
    end
    finish_run();
  end
endmodule